// File: doc/BRIEF.md
# Sync Source and Polarity Normalizer

This block sits between a display front end's sync inputs and its timing logic. The horizontal channel has two candidates: a dedicated sync pin and the output of a sync-on-green slicer. The vertical channel also has two: a vertical sync pin and the output of a composite sync separator. For each channel the block picks one source and turns it into an active-high pulse in the pixel clock domain.

Two choices are made for each channel: which source to use, and what the input polarity is. Each choice has its own override bit and forced value. When its override bit is clear, the block makes that choice itself, using a toggle-activity monitor on every input and a majority-level polarity detector on the chosen input. Status outputs report the activity flags, the chosen source and the detected polarity. The control bits arrive as plain inputs from a register file that lies outside this block.

Top module: `sync_normalizer`

## Requirements
- R1: Every raw input passes through a two-flop synchronizer. The normalized output then equals the selected input, inverted when the effective polarity is active low, three clocks after that input was sampled.
- R2: An input's activity flag (bit 0 = pin, bit 1 = alternate source) is set after the input toggles. It clears once 2^ACT_W clocks pass with no toggle.
- R3: With the source override at 0 and exactly one input active, the active input is selected. With neither active, the pin is selected. Source status encoding: 0 = pin, 1 = alternate.
- R4: With the source override at 0 and both inputs active, the select bit picks the source (0 = pin, 1 = alternate).
- R5: With the source override at 1, the select bit picks the source whatever the activity, one clock after the control is applied.
- R6: Automatic polarity counts high samples over a window of 2^POL_W clocks. If more than half are high, the detected polarity flag goes to 0 (active low). Otherwise it goes to 1 (active high).
- R7: With the polarity override at 1, the forced polarity bit sets the polarity (0 = active low, so the output is inverted; 1 = active high, so the output passes through). The detected flag is ignored.
- R8: The vertical channel follows R1 to R7 with vertical sync pin = 0 and separator = 1.
- R9: While reset is high, both sync outputs, all activity flags and both source flags are 0, and both detected polarity flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_pin_i | input | 1 | Raw dedicated horizontal sync pin |
| hs_sog_i | input | 1 | Raw sync-on-green slicer output |
| vs_pin_i | input | 1 | Raw vertical sync pin |
| vs_sep_i | input | 1 | Raw sync separator vertical output |
| hs_src_ovr | input | 1 | Horizontal source override enable |
| hs_src_sel | input | 1 | Horizontal source select (0 pin, 1 sync-on-green) |
| hs_pol_ovr | input | 1 | Horizontal polarity override enable |
| hs_pol_val | input | 1 | Forced horizontal polarity (1 active high) |
| vs_src_ovr | input | 1 | Vertical source override enable |
| vs_src_sel | input | 1 | Vertical source select (0 pin, 1 separator) |
| vs_pol_ovr | input | 1 | Vertical polarity override enable |
| vs_pol_val | input | 1 | Forced vertical polarity (1 active high) |
| hs_o | output | 1 | Normalized active-high horizontal sync |
| vs_o | output | 1 | Normalized active-high vertical sync |
| hs_act_o | output | 2 | Horizontal activity flags {sog, pin} |
| vs_act_o | output | 2 | Vertical activity flags {separator, pin} |
| hs_src_o | output | 1 | Chosen horizontal source |
| vs_src_o | output | 1 | Chosen vertical source |
| hs_pol_o | output | 1 | Detected horizontal polarity (1 active high) |
| vs_pol_o | output | 1 | Detected vertical polarity (1 active high) |

## Verification
Each input is driven with a pulse train of random period, width and polarity, or held idle. The combinations cover one input alive, the other alive, both alive, and none alive. A single live input separates automatic selection from the select bit. Both live shows that the select bit wins without the override. Forcing an idle source proves that the override beats activity. Active-low trains against forced polarities tell the detector's result apart from the forced value, and the outputs are compared sample by sample against the delayed raw inputs.

// File: rtl/sync_norm_pkg.sv
package sync_norm_pkg;

  // Control bits for one sync channel
  typedef struct packed {
    logic src_ovr;
    logic src_sel;
    logic pol_ovr;
    logic pol_val;
  } chan_ctrl_t;

  // Source encodings (also used on status outputs)
  localparam logic SRC_PIN = 1'b0;
  localparam logic SRC_ALT = 1'b1;

  // Polarity encodings
  localparam logic POL_LOW  = 1'b0;
  localparam logic POL_HIGH = 1'b1;

endpackage

// File: rtl/sync_norm_sync2.sv
module sync_norm_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;

endmodule

// File: rtl/sync_norm_activity.sv
module sync_norm_activity #(
  parameter int ACT_W = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic active
);

  localparam logic [ACT_W-1:0] CNT_MAX = '1;

  logic             prev_q;
  logic [ACT_W-1:0] idle_q;
  logic             act_q;
  logic             toggle;

  assign toggle = din ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      idle_q <= CNT_MAX;
      act_q  <= 1'b0;
    end else begin
      prev_q <= din;
      if (toggle) begin
        idle_q <= '0;
        act_q  <= 1'b1;
      end else if (idle_q == CNT_MAX) begin
        act_q  <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign active = act_q;

endmodule

// File: rtl/sync_norm_poldet.sv
module sync_norm_poldet #(
  parameter int POL_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pol_high
);

  import sync_norm_pkg::*;

  localparam int                 HW       = POL_W + 1;
  localparam logic [POL_W-1:0]   WIN_LAST = '1;
  localparam logic [HW-1:0]      HALF     = HW'(2 ** (POL_W - 1));

  logic [POL_W-1:0] pos_q;
  logic [HW-1:0]    hi_q;
  logic [HW-1:0]    hi_sum;
  logic             pol_q;

  assign hi_sum = hi_q + HW'(din);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      hi_q  <= '0;
      pol_q <= POL_HIGH;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == WIN_LAST) begin
        hi_q  <= '0;
        pol_q <= (hi_sum > HALF) ? POL_LOW : POL_HIGH;
      end else begin
        hi_q <= hi_sum;
      end
    end
  end

  assign pol_high = pol_q;

endmodule

// File: rtl/sync_norm_chan.sv
module sync_norm_chan #(
  parameter int ACT_W = 20,
  parameter int POL_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     raw_pin,
  input  logic                     raw_alt,
  input  sync_norm_pkg::chan_ctrl_t ctrl,
  output logic                     sync_o,
  output logic [1:0]               act_o,
  output logic                     src_o,
  output logic                     pol_o
);

  import sync_norm_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0] raw_vec;
  logic [NSRC-1:0] syn_vec;
  logic [NSRC-1:0] act_vec;
  logic            src_q;
  logic            src_nxt;
  logic            chosen;
  logic            det_pol;
  logic            pol_eff;
  logic            out_q;

  assign raw_vec = {raw_alt, raw_pin};

  sync_norm_sync2 #(.W(NSRC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_vec),
    .dout (syn_vec)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_act
    sync_norm_activity #(.ACT_W(ACT_W)) u_act (
      .clk    (clk),
      .rst    (rst),
      .din    (syn_vec[gi]),
      .active (act_vec[gi])
    );
  end

  always_comb begin
    if (ctrl.src_ovr || (act_vec == 2'b11)) begin
      src_nxt = ctrl.src_sel;
    end else if (act_vec[0]) begin
      src_nxt = SRC_PIN;
    end else if (act_vec[1]) begin
      src_nxt = SRC_ALT;
    end else begin
      src_nxt = SRC_PIN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_PIN;
    else     src_q <= src_nxt;
  end

  assign chosen = syn_vec[src_q];

  sync_norm_poldet #(.POL_W(POL_W)) u_pol (
    .clk      (clk),
    .rst      (rst),
    .din      (chosen),
    .pol_high (det_pol)
  );

  assign pol_eff = ctrl.pol_ovr ? ctrl.pol_val : det_pol;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= (pol_eff == POL_HIGH) ? chosen : ~chosen;
  end

  assign sync_o = out_q;
  assign act_o  = act_vec;
  assign src_o  = src_q;
  assign pol_o  = det_pol;

endmodule

// File: rtl/sync_normalizer.sv
module sync_normalizer #(
  parameter int ACT_W = 20,
  parameter int POL_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hs_pin_i,
  input  logic       hs_sog_i,
  input  logic       vs_pin_i,
  input  logic       vs_sep_i,
  input  logic       hs_src_ovr,
  input  logic       hs_src_sel,
  input  logic       hs_pol_ovr,
  input  logic       hs_pol_val,
  input  logic       vs_src_ovr,
  input  logic       vs_src_sel,
  input  logic       vs_pol_ovr,
  input  logic       vs_pol_val,
  output logic       hs_o,
  output logic       vs_o,
  output logic [1:0] hs_act_o,
  output logic [1:0] vs_act_o,
  output logic       hs_src_o,
  output logic       vs_src_o,
  output logic       hs_pol_o,
  output logic       vs_pol_o
);

  import sync_norm_pkg::*;

  chan_ctrl_t hs_ctrl;
  chan_ctrl_t vs_ctrl;

  assign hs_ctrl = '{src_ovr: hs_src_ovr, src_sel: hs_src_sel,
                     pol_ovr: hs_pol_ovr, pol_val: hs_pol_val};
  assign vs_ctrl = '{src_ovr: vs_src_ovr, src_sel: vs_src_sel,
                     pol_ovr: vs_pol_ovr, pol_val: vs_pol_val};

  sync_norm_chan #(.ACT_W(ACT_W), .POL_W(POL_W)) u_hs (
    .clk     (clk),
    .rst     (rst),
    .raw_pin (hs_pin_i),
    .raw_alt (hs_sog_i),
    .ctrl    (hs_ctrl),
    .sync_o  (hs_o),
    .act_o   (hs_act_o),
    .src_o   (hs_src_o),
    .pol_o   (hs_pol_o)
  );

  sync_norm_chan #(.ACT_W(ACT_W), .POL_W(POL_W)) u_vs (
    .clk     (clk),
    .rst     (rst),
    .raw_pin (vs_pin_i),
    .raw_alt (vs_sep_i),
    .ctrl    (vs_ctrl),
    .sync_o  (vs_o),
    .act_o   (vs_act_o),
    .src_o   (vs_src_o),
    .pol_o   (vs_pol_o)
  );

endmodule

// File: rtl/sync_normalizer_chk.sv
module sync_normalizer_chk (
  input logic       clk,
  input logic       rst,
  input logic       hs_src_ovr,
  input logic       hs_src_sel,
  input logic       vs_src_ovr,
  input logic       vs_src_sel,
  input logic       hs_o,
  input logic       vs_o,
  input logic [1:0] hs_act_o,
  input logic [1:0] vs_act_o,
  input logic       hs_src_o,
  input logic       vs_src_o,
  input logic       hs_pol_o,
  input logic       vs_pol_o
);

  AST_HS_FORCED_SRC: assert property (@(posedge clk) disable iff (rst)
    hs_src_ovr |=> (hs_src_o == $past(hs_src_sel))); // R5

  AST_VS_FORCED_SRC: assert property (@(posedge clk) disable iff (rst)
    vs_src_ovr |=> (vs_src_o == $past(vs_src_sel))); // R8

  AST_HS_BOTH_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!hs_src_ovr && hs_act_o == 2'b11) |=> (hs_src_o == $past(hs_src_sel))); // R4

  AST_HS_NONE_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!hs_src_ovr && hs_act_o == 2'b00) |=> (hs_src_o == 1'b0)); // R3

  AST_HS_ONE_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!hs_src_ovr && hs_act_o == 2'b10) |=> (hs_src_o == 1'b1)); // R3

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!hs_o && !vs_o && hs_act_o == 2'b00 && vs_act_o == 2'b00 &&
                    !hs_src_o && !vs_src_o && hs_pol_o && vs_pol_o)); // R9

endmodule

bind sync_normalizer sync_normalizer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hs_src_ovr (hs_src_ovr),
  .hs_src_sel (hs_src_sel),
  .vs_src_ovr (vs_src_ovr),
  .vs_src_sel (vs_src_sel),
  .hs_o       (hs_o),
  .vs_o       (vs_o),
  .hs_act_o   (hs_act_o),
  .vs_act_o   (vs_act_o),
  .hs_src_o   (hs_src_o),
  .vs_src_o   (vs_src_o),
  .hs_pol_o   (hs_pol_o),
  .vs_pol_o   (vs_pol_o)
);

// File: tb/sync_normalizer_tb.sv
module sync_normalizer_tb;

  localparam int ACT_W = 8;
  localparam int POL_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_pin_i = 1'b0, hs_sog_i = 1'b0, vs_pin_i = 1'b0, vs_sep_i = 1'b0;
  logic hs_src_ovr = 1'b0, hs_src_sel = 1'b0, hs_pol_ovr = 1'b0, hs_pol_val = 1'b1;
  logic vs_src_ovr = 1'b0, vs_src_sel = 1'b0, vs_pol_ovr = 1'b0, vs_pol_val = 1'b1;
  logic hs_o, vs_o, hs_src_o, vs_src_o, hs_pol_o, vs_pol_o;
  logic [1:0] hs_act_o, vs_act_o;

  always #4 clk = ~clk;

  sync_normalizer #(.ACT_W(ACT_W), .POL_W(POL_W)) u_dut (
    .clk(clk), .rst(rst),
    .hs_pin_i(hs_pin_i), .hs_sog_i(hs_sog_i), .vs_pin_i(vs_pin_i), .vs_sep_i(vs_sep_i),
    .hs_src_ovr(hs_src_ovr), .hs_src_sel(hs_src_sel), .hs_pol_ovr(hs_pol_ovr), .hs_pol_val(hs_pol_val),
    .vs_src_ovr(vs_src_ovr), .vs_src_sel(vs_src_sel), .vs_pol_ovr(vs_pol_ovr), .vs_pol_val(vs_pol_val),
    .hs_o(hs_o), .vs_o(vs_o), .hs_act_o(hs_act_o), .vs_act_o(vs_act_o),
    .hs_src_o(hs_src_o), .vs_src_o(vs_src_o), .hs_pol_o(hs_pol_o), .vs_pol_o(vs_pol_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // generator state, index 0 hs pin, 1 hs sog, 2 vs pin, 3 vs separator
  int per [4];
  int wid [4];
  int ph  [4];
  bit en  [4];
  bit ah  [4];
  logic [3:0] h0 = '0, h1 = '0, h2 = '0;
  int err_hs, err_vs;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_src(bit ovr, bit sel, bit a_pin, bit a_alt);
    if (ovr || (a_pin && a_alt)) return sel;
    if (a_pin) return 1'b0;
    if (a_alt) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_det(bit src, int base);
    int k = base + (src ? 1 : 0);
    return en[k] ? ah[k] : 1'b1;   // idle input sits low: seen as active high
  endfunction

  function automatic bit exp_eff(bit ovr, bit val, bit det);
    return ovr ? val : det;
  endfunction

  task automatic step(input bit chk);
    logic [3:0] nv;
    bit s, p;
    @(negedge clk);
    if (chk) begin
      s = exp_src(hs_src_ovr, hs_src_sel, en[0], en[1]);
      p = exp_eff(hs_pol_ovr, hs_pol_val, exp_det(s, 0));
      if (hs_o !== (p ? h2[s] : ~h2[s])) err_hs++;
      s = exp_src(vs_src_ovr, vs_src_sel, en[2], en[3]);
      p = exp_eff(vs_pol_ovr, vs_pol_val, exp_det(s, 2));
      if (vs_o !== (p ? h2[2 + s] : ~h2[2 + s])) err_vs++;
    end
    for (int i = 0; i < 4; i++) begin
      ph[i] = (ph[i] + 1) % per[i];
      nv[i] = en[i] ? ((ph[i] < wid[i]) ? ah[i] : ~ah[i]) : 1'b0;
    end
    h2 = h1; h1 = h0; h0 = nv;
    hs_pin_i = nv[0]; hs_sog_i = nv[1]; vs_pin_i = nv[2]; vs_sep_i = nv[3];
  endtask

  task automatic set_gen(input int i, input bit e, input bit high);
    en[i]  = e;
    ah[i]  = high;
    per[i] = 8 + int'($urandom_range(8));
    wid[i] = 1 + int'($urandom_range(per[i] / 4 - 1));
    ph[i]  = int'($urandom_range(per[i] - 1));
  endtask

  task automatic run_case();
    bit s, d, hs_both, vs_both;
    string tg;
    err_hs = 0; err_vs = 0;
    repeat (700) step(1'b0);
    repeat (200) step(1'b1);
    hs_both = en[0] && en[1];
    vs_both = en[2] && en[3];
    // R1 / R7 output stream for the horizontal channel
    tg = hs_pol_ovr ? "R7" : "R1";
    check(err_hs == 0, tg, err_hs, 0);
    // R8 vertical channel stream
    check(err_vs == 0, "R8", err_vs, 0);
    // R2 activity flags
    check(hs_act_o == {en[1], en[0]}, "R2", hs_act_o, {en[1], en[0]});
    check(vs_act_o == {en[3], en[2]}, "R2", vs_act_o, {en[3], en[2]});
    // R3 / R4 / R5 source choice
    s = exp_src(hs_src_ovr, hs_src_sel, en[0], en[1]);
    tg = hs_src_ovr ? "R5" : (hs_both ? "R4" : "R3");
    check(hs_src_o == s, tg, hs_src_o, s);
    s = exp_src(vs_src_ovr, vs_src_sel, en[2], en[3]);
    check(vs_src_o == s, "R8", vs_src_o, s);
    // R6 detected polarity
    d = exp_det(hs_src_o, 0);
    check(hs_pol_o == d, "R6", hs_pol_o, d);
    d = exp_det(vs_src_o, 2);
    check(vs_pol_o == d, "R8", vs_pol_o, d);
  endtask

  task automatic set_ctrl(input bit hso, input bit hss, input bit hpo, input bit hpv,
                          input bit vso, input bit vss, input bit vpo, input bit vpv);
    hs_src_ovr = hso; hs_src_sel = hss; hs_pol_ovr = hpo; hs_pol_val = hpv;
    vs_src_ovr = vso; vs_src_sel = vss; vs_pol_ovr = vpo; vs_pol_val = vpv;
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 4; i++) set_gen(i, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    // R9 reset state
    check(hs_o == 1'b0 && vs_o == 1'b0, "R9", {hs_o, vs_o}, 0);
    check(hs_act_o == 2'b00 && vs_act_o == 2'b00, "R9", {hs_act_o, vs_act_o}, 0);
    check(hs_src_o == 1'b0 && vs_src_o == 1'b0, "R9", {hs_src_o, vs_src_o}, 0);
    check(hs_pol_o == 1'b1 && vs_pol_o == 1'b1, "R9", {hs_pol_o, vs_pol_o}, 3);
    rst = 1'b0;

    // R3 R6: pin only, high pulses on hs, low pulses on vs
    set_gen(0, 1, 1); set_gen(1, 0, 1); set_gen(2, 1, 0); set_gen(3, 0, 1);
    set_ctrl(0, 0, 0, 1, 0, 0, 0, 1);
    run_case();
    // R3: alternate source only
    set_gen(0, 0, 1); set_gen(1, 1, 0); set_gen(2, 0, 1); set_gen(3, 1, 1);
    run_case();
    // R4: both live, select bit decides
    set_gen(0, 1, 1); set_gen(1, 1, 0); set_gen(2, 1, 0); set_gen(3, 1, 1);
    set_ctrl(0, 1, 0, 1, 0, 0, 0, 1);
    run_case();
    set_ctrl(0, 0, 0, 1, 0, 1, 0, 1);
    run_case();
    // R5: force an idle source
    set_gen(0, 1, 0); set_gen(1, 0, 1); set_gen(2, 0, 1); set_gen(3, 1, 0);
    set_ctrl(1, 1, 0, 1, 1, 0, 0, 1);
    run_case();
    // R7: forced polarity opposite to the detected one
    set_gen(0, 1, 1); set_gen(1, 0, 1); set_gen(2, 1, 0); set_gen(3, 0, 1);
    set_ctrl(0, 0, 1, 0, 0, 0, 1, 1);
    run_case();
    set_gen(0, 1, 0);
    set_ctrl(0, 0, 1, 1, 0, 0, 1, 0);
    run_case();
    // R2: everything goes quiet, flags time out
    for (int i = 0; i < 4; i++) set_gen(i, 1'b0, 1'b1);
    set_ctrl(0, 1, 0, 1, 0, 1, 0, 1);
    run_case();
    // random mix
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 4; i++) set_gen(i, 1'($urandom_range(1)), 1'($urandom_range(1)));
      set_ctrl(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
               1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      run_case();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule